// File: doc/BRIEF.md
# Three-Phase PWM Generator with Shared Period Edge

This block drives three phases of pulse-width modulation from one shared up-counter. Each phase has a positive output and a negative output, and the negative output is always the inverse of the positive one. The counter counts up from zero to the period value and then clears. When it clears, every positive output rises together, so all three phases share one edge at the start of the period. Each phase then falls at its own duty compare value.

Software writes the period and the three duty values through a simple write port. The writes go into buffer registers. The working compare values take the buffered values only when the counter clears at the period match, so the period and all three duties change together and no period ever mixes old and new values. While the start input is low, the counter is held at zero, all positive outputs are low, and the working values follow the buffers. This means a new run starts from freshly written values.

Top module: `rsync_pwm3`

## Requirements
- R1: After reset, all positive outputs are 0 and all negative outputs are 1. The period and duty buffers reset to 0.
- R2: In every cycle, each negative output equals the inverse of its phase's positive output.
- R3: While `run` is high, the counter begins at 0 in the first cycle of the run. It steps up by one each cycle until it equals the working period P, then returns to 0. Each period therefore lasts P+1 cycles.
- R4: For a phase with working duty D where 0 < D < P, the positive output is 1 while the count is below D, and 0 from count D through count P. All such phases rise together at count 0.
- R5: A working duty D that is greater than or equal to P holds that phase's positive output at 1 for the whole period.
- R6: A working duty of 0 with a nonzero period holds that phase's positive output at 0 for the whole period.
- R7: A write taken while running changes only a buffer. The working period and duties take the buffered values in the cycle that follows the count-equals-P cycle, so the current period finishes with the old values.
- R8: While `run` is low, the counter is held at 0, every positive output is 0, and the working values are reloaded from the buffers on each clock edge.
- R9: A write happens on a rising clock edge with `wr_en` high. `wr_sel` 0 selects the period buffer, and `wr_sel` 1, 2 and 3 select the duty buffers of phases 0, 1 and 2. With `wr_en` low, `wr_sel` and `wr_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High to count and drive outputs; low to stop and clear |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 2 | Buffer select: 0 period, 1 to 3 duty of phase 0 to 2 |
| wr_data | input | W | Value written to the selected buffer |
| pos_out | output | 3 | Positive PWM output, one bit per phase |
| neg_out | output | 3 | Inverted PWM output, one bit per phase |

## Verification
The outputs are decoded combinationally from the count and the working registers. The pattern for count 0 therefore appears in the same cycle that `run` rises, and each later count value appears one clock edge after the previous one. A buffer write lands on the edge that ends its strobe cycle. It reaches the outputs only in the first cycle after the count-equals-P cycle, or two edges later while stopped. The bench drives inputs on the falling edge and samples one time unit later. It queues one expected output vector per cycle of each period, in count order, and pops one vector per cycle once the run begins. Writes are placed so that each one commits before the wrap edge it is meant to reach.

// File: rtl/rsync_pwm3.sv
module rsync_pwm3 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [2:0]   pos_out,
  output logic [2:0]   neg_out
);
  localparam int NPH = 3;

  logic [W-1:0]          cnt, per_buf, per_act;
  logic [NPH-1:0][W-1:0] duty_buf, duty_act;
  logic                  wrap, reload;

  assign wrap   = (cnt == per_act);
  assign reload = !run || wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_buf  <= '0;
      duty_buf <= '0;
    end else if (wr_en) begin
      if (wr_sel == 2'd0) per_buf <= wr_data;
      for (int i = 0; i < NPH; i++)
        if (wr_sel == 2'(i + 1)) duty_buf[i] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else if (reload) begin
      cnt      <= '0;
      per_act  <= per_buf;
      duty_act <= duty_buf;
    end else begin
      cnt <= cnt + W'(1);
    end
  end

  for (genvar g = 0; g < NPH; g++) begin : g_phase
    assign pos_out[g] = run && ((cnt < duty_act[g]) || (duty_act[g] >= per_act));
  end

  assign neg_out = ~pos_out;
endmodule

// File: rtl/rsync_pwm3_chk.sv
module rsync_pwm3_chk #(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [2:0]        pos_out,
  input logic [2:0]        neg_out,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      per_act,
  input logic [2:0][W-1:0] duty_act
);
  a_r2_neg_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    neg_out == ~pos_out);

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != per_act) |=> (!run || cnt == $past(cnt) + W'(1)));

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == per_act) |=> cnt == '0);

  a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> pos_out == 3'b000);

  a_r8_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  a_r7_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != per_act) |=> ($stable(per_act) && $stable(duty_act)));

  a_r6_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (run && per_act != '0 && duty_act[0] == '0) |-> !pos_out[0]);

  a_r4_common_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0 && duty_act[0] != '0 && duty_act[1] != '0 && duty_act[2] != '0)
      |-> pos_out == 3'b111);
endmodule

bind rsync_pwm3 rsync_pwm3_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .pos_out(pos_out), .neg_out(neg_out),
  .cnt(cnt), .per_act(per_act), .duty_act(duty_act)
);

// File: tb/rsync_pwm3_tb.sv
module rsync_pwm3_tb;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n, run, wr_en;
  logic [1:0]   wr_sel;
  logic [W-1:0] wr_data;
  logic [2:0]   pos_out, neg_out;

  typedef struct {
    logic [2:0] p;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  rsync_pwm3 #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pos_out(pos_out), .neg_out(neg_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input int val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_sel = sel;
    wr_data = W'(val);
  endtask

  task automatic wr_end();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_period(input int per, input int d0, input int d1, input int d2, input string tag);
    int d[3];
    d = '{d0, d1, d2};
    for (int k = 0; k <= per; k++) begin
      exp_t e;
      for (int i = 0; i < 3; i++)
        e.p[i] = (d[i] >= per) || (k < d[i]);
      e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic run_until_empty();
    while (q.size() != 0) @(negedge clk);
    run = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (q.size() > 0) begin
          exp_t e;
          e = q.pop_front();
          chk(pos_out === e.p, e.tag, pos_out, e.p);
        end else if (!run) begin
          chk(pos_out === 3'b000, "R8 idle low", pos_out, 3'b000);
        end
        chk(neg_out === ~pos_out, "R2 inverse", neg_out, ~pos_out);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst_n = 1'b0; run = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pos_out === 3'b000, "R1 reset pos", pos_out, 3'b000);
    chk(neg_out === 3'b111, "R1 reset neg", neg_out, 3'b111);

    // R9 encoding: sel 0 period, 1..3 duty of phase 0..2
    wr(2'd0, 5); wr(2'd1, 2); wr(2'd2, 5); wr(2'd3, 0); wr_end();
    @(negedge clk);
    push_period(5, 2, 5, 0, "R3 R4 R5 R6 first period");
    push_period(3, 1, 7, 3, "R7 R5 values written mid period");
    run = 1'b1;
    wr(2'd0, 3); wr(2'd1, 1); wr(2'd2, 7); wr(2'd3, 3); wr_end();
    run_until_empty();

    wr(2'd1, 4); wr(2'd2, 4); wr(2'd3, 6); wr(2'd0, 7); wr_end();
    @(negedge clk);
    push_period(7, 4, 4, 6, "R4 R3 common rising edge");
    run = 1'b1;
    run_until_empty();

    wr(2'd0, 2); wr(2'd1, 0); wr(2'd2, 2); wr(2'd3, 1); wr_end();
    // R9: strobe low, select and data must be ignored
    wr_sel = 2'd0; wr_data = W'(9);
    @(negedge clk);
    wr_sel = 2'd1; wr_data = W'(9);
    @(negedge clk);
    push_period(2, 0, 2, 1, "R9 R6 R5 R4 strobe-low ignored");
    push_period(2, 0, 2, 1, "R9 R3 repeat period");
    run = 1'b1;
    run_until_empty();

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule